// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block connects two 18-bit buses, A and B, through two separate storage paths: one carries A data toward B, the other carries B data toward A. Each path has three controls of its own: a pass control, a strobe and a drive enable. While its pass control is high, a path is transparent and its output follows the live input. While the pass control is low, the path holds its stored word. A falling strobe loads a new word into that storage.

Each bus is modelled as three signals: an input vector, an output vector and an output-enable bit. A surrounding pad ring or a bench can combine these into a shared wire. The drive enable for the B side is active high. The drive enable for the A side is active low.

The block runs from one fabric clock. The pass and strobe controls are sampled as synchronous levels, and each strobe's falling edge is found by comparing the level at this clock edge with the level at the previous one.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While rst_n is low, both stored words are zero, so with both pass controls low, a_out and b_out read 0.
- R2: While ab_pass is high, b_out equals a_in in the same cycle, with no clock needed.
- R3: While ab_pass is low and no strobe fall is seen, b_out keeps its value from one clock to the next, whatever a_in does.
- R4: A strobe fall is a clock edge where ab_strobe is sampled low and was sampled high at the previous edge (taken as low after reset). At such an edge with ab_pass low, a_in is stored, and b_out shows it from that edge on.
- R5: A rising ab_strobe with ab_pass low leaves b_out unchanged.
- R6: When ab_pass goes low, the path holds the a_in value present at the last clock edge where ab_pass was high, even if a_in changes in the same cycle.
- R7: b_oe is high exactly when ab_drive is high, which is an active-high enable. When b_oe is low, the B side counts as high impedance.
- R8: a_oe is high exactly when ba_drive_n is low, which is an active-low enable.
- R9: The B-to-A path behaves as in R2 to R6, using b_in, ba_pass and ba_strobe to drive a_out. Neither path's controls affect the other path's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Data arriving from bus A |
| a_out | output | 18 | Data driven toward bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 18 | Data arriving from bus B |
| b_out | output | 18 | Data driven toward bus B |
| b_oe | output | 1 | Drive enable for bus B |
| ab_pass | input | 1 | A-to-B transparent control |
| ab_strobe | input | 1 | A-to-B load strobe, falling edge |
| ab_drive | input | 1 | B-side enable, active high |
| ba_pass | input | 1 | B-to-A transparent control |
| ba_strobe | input | 1 | B-to-A load strobe, falling edge |
| ba_drive_n | input | 1 | A-side enable, active low |

## Verification
The bench uses three kinds of stimulus:

- **Random run:** fresh data arrives every cycle while the pass controls, strobes and enables change at random. A reference model compares both outputs on every cycle. Long holds with a toggling strobe separate a design that loads on the falling edge from one that loads on the rising edge or on every edge.
- **Directed R5 and R6 sequences:** the bench changes data in the same cycle as a pass drop or a rising strobe. This exposes designs that capture late or load on the wrong strobe edge.
- **One-path-only activity:** the bench exercises one path while the other stays idle. This shows whether the two paths share any state.

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_pass,
  input  logic             ab_strobe,
  input  logic             ab_drive,
  input  logic             ba_pass,
  input  logic             ba_strobe,
  input  logic             ba_drive_n
);

  logic [WIDTH-1:0] ab_hold, ba_hold;
  logic             ab_strobe_q, ba_strobe_q;

  wire ab_fall = ab_strobe_q & ~ab_strobe;
  wire ba_fall = ba_strobe_q & ~ba_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_hold     <= '0;
      ab_strobe_q <= 1'b0;
    end else begin
      ab_strobe_q <= ab_strobe;
      if (ab_pass || ab_fall) ab_hold <= a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_hold     <= '0;
      ba_strobe_q <= 1'b0;
    end else begin
      ba_strobe_q <= ba_strobe;
      if (ba_pass || ba_fall) ba_hold <= b_in;
    end
  end

  assign b_out = ab_pass ? a_in : ab_hold;
  assign a_out = ba_pass ? b_in : ba_hold;
  assign b_oe  = ab_drive;
  assign a_oe  = ~ba_drive_n;

endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             ab_pass,
  input logic             ab_strobe,
  input logic             ab_drive,
  input logic             ba_pass,
  input logic             ba_strobe,
  input logic             ba_drive_n
);

  p_pass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ab_pass |-> b_out == a_in);

  p_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && $past(!ab_pass) && !($past(ab_strobe, 2) && !$past(ab_strobe)))
      |-> $stable(b_out));

  p_capture_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_pass && $past(ab_strobe, 2) && !$past(ab_strobe)) |-> b_out == $past(a_in));

  p_drive_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ab_drive |-> b_oe);

  p_drive_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_drive_n |-> a_oe);

  p_pass_follow_ba_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ba_pass |-> a_out == b_in);

  p_hold_ba_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_pass && $past(!ba_pass) && !($past(ba_strobe, 2) && !$past(ba_strobe)))
      |-> $stable(a_out));

endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_pass(ab_pass),
  .ab_strobe(ab_strobe), .ab_drive(ab_drive), .ba_pass(ba_pass),
  .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n)
);

// File: tb/tb_reg_bus_xcvr.sv
`timescale 1ns/1ps
module tb_reg_bus_xcvr;
  localparam int W = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_oe, b_oe;
  logic ab_pass = 0, ab_strobe = 0, ab_drive = 0;
  logic ba_pass = 0, ba_strobe = 0, ba_drive_n = 1;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reg_bus_xcvr #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ab_pass(ab_pass),
    .ab_strobe(ab_strobe), .ab_drive(ab_drive), .ba_pass(ba_pass),
    .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n)
  );

  // behavioural reference: stored words and last sampled strobe levels
  int m_ab = 0, m_ba = 0;
  bit s_ab = 0, s_ba = 0, f_ab = 0, f_ba = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab <= 0; m_ba <= 0; s_ab <= 0; s_ba <= 0; f_ab <= 0; f_ba <= 0;
    end else begin
      f_ab <= s_ab && !ab_strobe && !ab_pass;
      f_ba <= s_ba && !ba_strobe && !ba_pass;
      if (ab_pass || (s_ab && !ab_strobe)) m_ab <= int'(a_in);
      if (ba_pass || (s_ba && !ba_strobe)) m_ba <= int'(b_in);
      s_ab <= ab_strobe;
      s_ba <= ba_strobe;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(ab_pass ? "R2" : (f_ab ? "R4" : "R3"), int'(b_out), ab_pass ? int'(a_in) : m_ab);
    chk("R9", int'(a_out), ba_pass ? int'(b_in) : m_ba);
    chk("R7", int'(b_oe), int'(ab_drive));
    chk("R8", int'(a_oe), int'(!ba_drive_n));
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a_in = 18'h2AAAA; b_in = 18'h15555;
    repeat (3) @(negedge clk);
    chk("R1", int'(b_out), 0);
    chk("R1", int'(a_out), 0);
    rst_n = 1'b1;
    step();

    // R6: pass drop with data change in the same cycle
    ab_pass = 1; a_in = 18'h12345;
    step();
    ab_pass = 0; a_in = 18'h0F0F0;
    step();
    chk("R6", int'(b_out), 18'h12345);

    // R5: rising strobe leaves the word alone
    a_in = 18'h3C3C3;
    ab_strobe = 1;
    step();
    chk("R5", int'(b_out), 18'h12345);
    step();
    chk("R5", int'(b_out), 18'h12345);

    // R4: falling strobe loads
    ab_strobe = 0;
    step();
    chk("R4", int'(b_out), 18'h3C3C3);

    // R9: A-to-B activity does not reach a_out
    ba_pass = 1; b_in = 18'h00777;
    step();
    ba_pass = 0; b_in = 18'h11111;
    ab_strobe = 1; step(); ab_strobe = 0; a_in = 18'h22222; step();
    chk("R9", int'(a_out), 18'h00777);
    chk("R4", int'(b_out), 18'h22222);

    // R7/R8 every enable combination
    for (int k = 0; k < 4; k++) begin
      ab_drive = k[0]; ba_drive_n = k[1];
      step();
    end

    // random mixed run
    for (int i = 0; i < 4000; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      ab_pass = ($urandom % 6) == 0;
      ba_pass = ($urandom % 6) == 0;
      if (($urandom % 3) == 0) ab_strobe = ~ab_strobe;
      if (($urandom % 3) == 0) ba_strobe = ~ba_strobe;
      ab_drive = $urandom % 2;
      ba_drive_n = $urandom % 2;
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule